// File: doc/BRIEF.md
# Serial Cut-Through Broadcast Repeater

This block sits on a node that has eight bit-serial links to its neighbours, two for each dimension of a four-dimensional mesh. One incoming link is chosen as the source. Every bit arriving on that link is copied to a chosen set of the other outgoing links, up to seven at once. The copy goes out a fixed four clock cycles after the bit arrives. Forwarding does not wait for the rest of the 32-bit word. Because each node repeats a word while it is still arriving, a broadcast can cross many nodes with only a few cycles added at each hop.

On a link, a word is framed as a single 1 (the start marker) followed by 32 data bits, least significant bit first. An idle link holds 0. The repeater also unpacks each frame from the source for local use. It presents the 32-bit value with a one-cycle valid pulse.

The source index and the lane mask come in as level inputs. They are taken into the working configuration only in cycles when no frame is passing through. Any lane bit that points back at the source link is cleared when the configuration is taken in.

Top module: `bcast_repeater`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, every outgoing link, `rx_valid` and `rx_word` are 0. Reset also clears the working lane set, so nothing is forwarded until a configuration has been taken in.
- R2: Timing of forwarded bits:
  - A bit present on the source link during cycle k appears on every enabled outgoing link during cycle k+4.
  - This holds for the start marker and for every data bit.
  - Output begins while later bits of the same word are still arriving.
- R3: An outgoing link whose bit in `cfg_mask` (bit i controls link i) was 0 when the configuration was taken in stays at 0.
- R4: The outgoing link with the same index as the source stays at 0, even when its mask bit is set.
- R5: Activity on links other than the source has no effect on any outgoing link or on the local word.
- R6: Frame format and local delivery:
  - A frame is a 1 followed by 32 data bits, LSB first.
  - If the start marker is on the source during cycle k, `rx_valid` is high for exactly the one cycle k+33.
  - During that cycle `rx_word` holds the 32 data bits.
- R7: `rx_word` keeps its value until the next frame completes.
- R8: When the configuration is taken in:
  - `cfg_src`/`cfg_mask` are taken in only when no frame is in progress. A frame is in progress from its start marker until its last bit has left the outgoing links.
  - The source link must also be 0 in that cycle.
  - A change presented in the middle of a frame leaves that frame's forwarding unchanged and takes effect once the frame has drained.
- R9: A start marker in the cycle right after the 32nd data bit begins a new frame. Back-to-back frames are forwarded and delivered without a gap.
- R10: A 1 among the data bits of a frame is treated as data, never as a new start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | 3 | Requested source link index |
| cfg_mask | input | 8 | Requested outgoing lane set, bit i for link i |
| link_in | input | 8 | Incoming serial links |
| link_out | output | 8 | Outgoing serial links (registered) |
| rx_valid | output | 1 | One-cycle pulse when a local word is complete |
| rx_word | output | 32 | Last word received from the source link |

## Verification
Some behaviours are checked by assertions on every cycle:
- Each outgoing link equals the source bit from four cycles earlier, gated by the lane set.
- Disabled lanes and the source's own lane stay silent.
- The configuration holds still whenever a frame is in flight or starting.
- `rx_valid` never lasts two cycles.
- `rx_word` moves only with a valid pulse.

Other behaviours need the bench's scenarios:
- A configuration change made in the middle of a frame is deferred, and then takes effect on the next frame.
- Back-to-back frames are split correctly.
- Data words full of ones do not restart framing.
- Noise on non-source links leaves both the forwarded stream and the local word untouched.

// File: rtl/bcast_pkg.sv
`timescale 1ns/1ps
package bcast_pkg;
  localparam int unsigned DEF_LINKS = 8;
  localparam int unsigned DEF_WORD  = 32;
  localparam int unsigned DEF_LAT   = 4;
endpackage

// File: rtl/bcast_frame_tracker.sv
`timescale 1ns/1ps
module bcast_frame_tracker #(
  parameter int unsigned WORD_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic frm_start,
  output logic frm_data,
  output logic frm_last
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0] left_q;

  // A marker is only recognised when no data bits are still owed.
  assign frm_start = (left_q == '0) && bit_in;
  assign frm_data  = (left_q != '0);
  assign frm_last  = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (frm_start) begin
      left_q <= CNT_W'(WORD_W);
    end else if (frm_data) begin
      left_q <= left_q - CNT_W'(1);
    end
  end

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    frm_last |=> (left_q == '0)) else $error("tracker not ready after last bit"); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    frm_data |=> (left_q < CNT_W'(WORD_W))) else $error("data bit restarted count"); // R10
endmodule

// File: rtl/bcast_fwd_pipe.sv
`timescale 1ns/1ps
module bcast_fwd_pipe #(
  parameter int unsigned N_LINKS = 8,
  parameter int unsigned LAT     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  input  logic [N_LINKS-1:0] lane_en,
  output logic [N_LINKS-1:0] dout
);
  localparam int unsigned PRE = LAT - 1;

  logic [PRE-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int j = 1; j < PRE; j++) stg_q[j] <= stg_q[j-1];
    end
  end

  // The last stage is one output register per lane.
  for (genvar i = 0; i < N_LINKS; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) dout[i] <= 1'b0;
      else     dout[i] <= stg_q[PRE-1] & lane_en[i];
    end
  end
endmodule

// File: rtl/bcast_word_deser.sv
`timescale 1ns/1ps
module bcast_word_deser #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              frm_data,
  input  logic              frm_last,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= frm_last;
      if (frm_data) sh_q <= {bit_in, sh_q[WORD_W-1:1]};
      if (frm_last) word_out <= {bit_in, sh_q[WORD_W-1:1]};
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid) else $error("valid longer than one cycle"); // R6

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_out)) else $error("word moved without valid"); // R7
endmodule

// File: rtl/bcast_repeater.sv
`timescale 1ns/1ps
module bcast_repeater
  import bcast_pkg::*;
#(
  parameter int unsigned N_LINKS = DEF_LINKS,
  parameter int unsigned WORD_W  = DEF_WORD,
  parameter int unsigned LAT     = DEF_LAT,
  localparam int unsigned SRC_W  = $clog2(N_LINKS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SRC_W-1:0]   cfg_src,
  input  logic [N_LINKS-1:0] cfg_mask,
  input  logic [N_LINKS-1:0] link_in,
  output logic [N_LINKS-1:0] link_out,
  output logic               rx_valid,
  output logic [WORD_W-1:0]  rx_word
);
  localparam int unsigned DRAIN  = WORD_W + LAT;
  localparam int unsigned DR_W   = $clog2(DRAIN + 1);
  localparam int unsigned WARM_W = $clog2(LAT + 1);

  logic [SRC_W-1:0]   src_q;
  logic [N_LINKS-1:0] lane_q;
  logic [DR_W-1:0]    drain_q;
  logic [N_LINKS-1:0] cfg_src_oh;
  logic               sel_bit, busy;
  logic               frm_start, frm_data, frm_last;

  assign sel_bit = link_in[src_q];
  assign busy    = (drain_q != '0);

  always_comb begin
    cfg_src_oh          = '0;
    cfg_src_oh[cfg_src] = 1'b1;
  end

  // Configuration is taken in only when nothing is in flight or starting.
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      lane_q <= '0;
    end else if (!busy && !sel_bit) begin
      src_q  <= cfg_src;
      lane_q <= cfg_mask & ~cfg_src_oh;
    end
  end

  // Covers a frame from its marker until its last bit leaves the outputs.
  always_ff @(posedge clk) begin
    if (rst)            drain_q <= '0;
    else if (frm_start) drain_q <= DR_W'(DRAIN);
    else if (busy)      drain_q <= drain_q - DR_W'(1);
  end

  bcast_frame_tracker #(.WORD_W(WORD_W)) u_track (
    .clk(clk), .rst(rst), .bit_in(sel_bit),
    .frm_start(frm_start), .frm_data(frm_data), .frm_last(frm_last)
  );

  bcast_fwd_pipe #(.N_LINKS(N_LINKS), .LAT(LAT)) u_fwd (
    .clk(clk), .rst(rst), .din(sel_bit), .lane_en(lane_q), .dout(link_out)
  );

  bcast_word_deser #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst(rst), .bit_in(sel_bit), .frm_data(frm_data),
    .frm_last(frm_last), .word_valid(rx_valid), .word_out(rx_word)
  );

  // ---------------- assertions ----------------
  logic [WARM_W-1:0]  warm_q;
  logic [N_LINKS-1:0] src_oh_q;

  always_ff @(posedge clk) begin
    if (rst)                         warm_q <= '0;
    else if (warm_q != WARM_W'(LAT)) warm_q <= warm_q + WARM_W'(1);
  end

  always_comb begin
    src_oh_q        = '0;
    src_oh_q[src_q] = 1'b1;
  end

  if (LAT == 4) begin : g_lat_chk
    AST_FWD_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (warm_q == WARM_W'(LAT)) |-> (link_out == ($past(sel_bit, 4) ? lane_q : '0)))
      else $error("forward latency broken"); // R2
  end

  AST_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (link_out & ~lane_q) == '0) else $error("disabled lane active"); // R3

  AST_SRC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (link_out & src_oh_q) == '0) else $error("source lane echoed"); // R4

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy || sel_bit) |=> ($stable(src_q) && $stable(lane_q)))
    else $error("config changed during frame"); // R8
endmodule

// File: tb/bcast_repeater_tb.sv
`timescale 1ns/1ps
module bcast_repeater_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_src = '0;
  logic [7:0]  cfg_mask = '0;
  logic [7:0]  link_in = '0;
  logic [7:0]  link_out;
  logic        rx_valid;
  logic [31:0] rx_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcast_repeater u_dut (
    .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_mask(cfg_mask),
    .link_in(link_in), .link_out(link_out), .rx_valid(rx_valid), .rx_word(rx_word)
  );

  // {src[2:0], mask[7:0], word[31:0]}
  localparam logic [42:0] VEC [6] = '{
    {3'd0, 8'hFE, 32'hA5C3_0F81},
    {3'd3, 8'hFF, 32'hFFFF_FFFF},
    {3'd7, 8'h00, 32'h1234_5678},
    {3'd1, 8'h02, 32'h8000_0001},
    {3'd4, 8'h5A, 32'h0000_0000},
    {3'd6, 8'hC3, 32'hDEAD_BEEF}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [127:0] frame1(input logic [31:0] w);
    return {95'b0, w, 1'b1};
  endfunction

  task automatic run_stream(input logic [127:0] st, input int len, input logic [2:0] src,
                            input logic [7:0] emask, input logic [31:0] w0, input logic [31:0] w1,
                            input int nwords, input bit noise, input int chg_at,
                            input logic [2:0] nsrc, input logic [7:0] nmask, input string req);
    for (int c = 0; c < len + 6; c++) begin
      logic [7:0] v;
      logic eb;
      @(negedge clk);
      eb = (c >= 4 && c - 4 < len) ? st[c-4] : 1'b0;
      chk(link_out == (eb ? emask : 8'h00), req, 64'(link_out), 64'(eb ? emask : 8'h00));
      chk(rx_valid == ((c == 33) || (nwords == 2 && c == 66)), "R6 valid", 64'(rx_valid), 64'(c == 33 || (nwords == 2 && c == 66)));
      if (c == 33) chk(rx_word == w0, "R6 word", 64'(rx_word), 64'(w0));
      if (nwords == 2 && c == 66) chk(rx_word == w1, "R9 word", 64'(rx_word), 64'(w1));
      if (nwords == 2 && c > 33 && c < 66) chk(rx_word == w0, "R7 hold", 64'(rx_word), 64'(w0));
      v = (noise && c < len) ? (8'((c * 91 + 23) ^ (c << 3)) & ~(8'b1 << src)) : 8'h00;
      if (c < len) v[src] = st[c];
      link_in = v;
      if (c == chg_at) begin
        cfg_src  = nsrc;
        cfg_mask = nmask;
      end
    end
    link_in = '0;
  endtask

  task automatic set_cfg(input logic [2:0] s, input logic [7:0] m);
    cfg_src = s;
    cfg_mask = m;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    cfg_src = 3'd0; cfg_mask = 8'hFF;
    repeat (3) @(negedge clk);
    chk(link_out == 8'h00, "R1 out", 64'(link_out), 64'h0);
    chk(rx_valid == 1'b0, "R1 valid", 64'(rx_valid), 64'h0);
    chk(rx_word == 32'h0, "R1 word", 64'(rx_word), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(link_out == 8'h00 && !rx_valid && rx_word == 0, "R1 after release", 64'(link_out), 64'h0);

    // R2 R3 R4 R5 R6 R10: table walk, noise on non-source links
    foreach (VEC[i]) begin
      logic [2:0] s;
      logic [7:0] m;
      logic [31:0] w;
      {s, m, w} = VEC[i];
      set_cfg(s, m);
      run_stream(frame1(w), 33, s, m & ~(8'b1 << s), w, 32'h0, 1, 1, -1, s, m, "R2 R3 R4 R5 R10 fwd");
    end

    // R9 R7: back-to-back frames
    set_cfg(3'd5, 8'hFF);
    run_stream({62'b0, 32'h0F0F_3CC3, 1'b1, 32'h7E81_FFFE, 1'b1}, 66, 3'd5, 8'hDF,
               32'h7E81_FFFE, 32'h0F0F_3CC3, 2, 1, -1, 3'd5, 8'hFF, "R9 fwd");

    // R8: change requested mid-frame applies only after drain
    set_cfg(3'd2, 8'h0F);
    run_stream(frame1(32'hC001_D00D), 33, 3'd2, 8'h0B, 32'hC001_D00D, 32'h0, 1, 0,
               10, 3'd6, 8'hF0, "R8 deferred");
    repeat (2) @(negedge clk);
    run_stream(frame1(32'h2468_ACE1), 33, 3'd6, 8'hB0, 32'h2468_ACE1, 32'h0, 1, 1,
               -1, 3'd6, 8'hF0, "R8 applied");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule